// File: doc/BRIEF.md
# SDRAM Command Sequencer with Per-Bank Row Tracking

This block turns queued memory requests into a stream of DDR3-style commands. Each request carries a 2-bit operation code, a 3-bit bank number, a 13-bit row and a 13-bit column. After reset the sequencer waits out a power-up interval, closes every bank and issues one refresh. Only then does it offer to take requests. From that point it activates rows, issues column reads and writes, closes rows when a request needs a different one, and inserts periodic refreshes.

The sequencer remembers, for each of its banks, whether a row is open and which row it is. A normal read or a write always reopens the row: if the bank is open it is closed first. A fast read reuses the open row when it already matches and goes straight to the column command. Before any refresh, all banks are forced closed with a single close-all command. A pending refresh outranks every queued request.

The command, bank and address outputs are registered. The request handshake is valid/ready, and two strobes mark the cycles that carry write and read column commands so the data path can move data.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is first sampled high, `cmd_o` is NOP, `init_done_o` is 0 and `req_ready_o` is 0. A command sequence that was in flight is abandoned. After release, all banks count as closed.
- R2: After reset, `init_done_o` and `req_ready_o` stay 0 and no request is taken until initialization finishes. Initialization is a power-up wait of `INIT_CYC` cycles, then a close-all (PRE with `addr_o[10]`=1), then REF exactly `T_RP` cycles later. `init_done_o` rises `T_RFC` cycles after the REF.
- R3: The command codes on `cmd_o` are NOP=0, ACT=1, RD=2, WR=3, PRE=4 and REF=5. The request opcodes are 2'b01 normal read, 2'b10 write and 2'b11 fast read. `wr_go_o` is high exactly in the cycles that carry WR, and `rd_go_o` exactly in the cycles that carry RD.
- R4: `ba_o` carries the request's bank number in binary (0 to 7) on ACT, single-bank PRE, RD and WR. The open-row state of each bank is kept separately, and opening one bank does not change another.
- R5: When `cmd_o` is PRE, `addr_o[10]`=1 closes every bank and `addr_o[10]`=0 closes only the bank on `ba_o`. On RD and WR, `addr_o` is the column with bit 10 forced to 0.
- R6: For a normal read or a write, an open target bank (any row) gets PRE in the cycle after acceptance, ACT with the row `T_RP` cycles later, and the column command `T_RCD` cycles after that. A closed bank gets ACT in the cycle after acceptance and the column command `T_RCD` cycles later.
- R7: For a fast read whose row is already open in the target bank, RD appears in the cycle after acceptance, with no PRE or ACT. On a row miss or a closed bank, a fast read follows the R6 sequence.
- R8: A request with opcode 2'b00 is taken (ready and valid both high) and produces no command.
- R9: A refresh becomes pending every `REFI` cycles. While it is pending, `req_ready_o` is 0. If any bank is open, a close-all PRE is issued and REF follows `T_RP` cycles later. If no bank is open, REF is issued directly. After REF, every bank counts as closed.
- R10: After a column command the sequencer can take a new request in the next cycle. After REF it issues nothing for `T_RFC` cycles, and `req_ready_o` stays 0 until the `T_RFC`-th cycle after REF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request queue head is valid |
| req_ready_o | output | 1 | Sequencer takes the head request this cycle |
| req_op_i | input | 2 | Operation: 00 none, 01 read, 10 write, 11 fast read |
| req_bank_i | input | 3 | Target bank |
| req_row_i | input | 13 | Target row |
| req_col_i | input | 13 | Target column |
| cmd_o | output | 3 | Registered command code |
| ba_o | output | 3 | Registered bank select |
| addr_o | output | 13 | Registered address; bit 10 is the all-banks / auto flag |
| wr_go_o | output | 1 | Write data to be driven for this WR |
| rd_go_o | output | 1 | Read data to be captured for this RD |
| init_done_o | output | 1 | Initialization complete |

## Verification
A wrong open-row bit shows at the ports when the next request reaches that bank. A stale "open" bit gives a spurious PRE, or a lone RD to a closed bank. A lost bit gives an ACT on top of an open row. Either appears in the first cycle after acceptance. Wrong wait-counter state moves the ACT or the column command away from its fixed `T_RP` or `T_RCD` offset, so the bench checks exact cycle offsets. A fault in the refresh path shows as a fast-read stream that never yields a REF, or as a REF with banks still open. The row-closing effect of that REF becomes visible at the first request after the `T_RFC` window.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;
  localparam logic [1:0] OP_FRD  = 2'b11;

  // step launched when a wait expires (or straight from idle)
  typedef enum logic [2:0] {
    STEP_PRE,
    STEP_ACT,
    STEP_COL,
    STEP_PREALL,
    STEP_REF,
    STEP_DONE
  } step_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } seq_st_e;

  localparam int A10_BIT = 10;

endpackage

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int REFI = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  output logic pending_o
);
  localparam int CNT_W = $clog2(REFI + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (ack_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cnt_q == CNT_W'(REFI - 1)) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/seq_bank_table.sv
module seq_bank_table
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 13,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] look_bank_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [ADDR_W-1:0] look_row_o
);
  logic [ADDR_W-1:0] row_mem [NUM_BANKS];

  // row storage: no reset, single write port, async read
  always_ff @(posedge clk) begin
    if (cmd_i == CMD_ACT) row_mem[ba_i] <= addr_i;
  end

  assign look_row_o = row_mem[look_bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_open
    always_ff @(posedge clk) begin
      if (rst) begin
        open_o[b] <= 1'b0;
      end else if (cmd_i == CMD_ACT && ba_i == BANK_W'(b)) begin
        open_o[b] <= 1'b1;
      end else if (cmd_i == CMD_PRE && (addr_i[A10_BIT] || ba_i == BANK_W'(b))) begin
        open_o[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 13,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 8,
  parameter int REFI      = 780,
  parameter int INIT_CYC  = 40,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [ADDR_W-1:0] req_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_go_o,
  output logic              rd_go_o,
  output logic              init_done_o
);
  localparam int T_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int T_B   = (T_RFC > INIT_CYC) ? T_RFC : INIT_CYC;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << A10_BIT;

  seq_st_e           st_q, st_d;
  step_e             step_q, step_d, launch;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic [1:0]        op_q, op_d, cur_op;
  logic [BANK_W-1:0] bank_q, bank_d, cur_bank;
  logic [ADDR_W-1:0] row_q, row_d, cur_row;
  logic [ADDR_W-1:0] col_q, col_d, cur_col;
  logic              done_q, done_d;
  cmd_e              cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d, wr_q, wr_d;
  logic              fire, ref_ack, ref_pend, accept;
  logic [NUM_BANKS-1:0] open_vec;
  logic [ADDR_W-1:0] look_row;
  logic              bank_open, row_hit;

  seq_refresh_timer #(.REFI(REFI)) u_refresh (
    .clk       (clk),
    .rst       (rst),
    .ack_i     (ref_ack),
    .pending_o (ref_pend)
  );

  seq_bank_table #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_banks (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd_q),
    .ba_i        (ba_q),
    .addr_i      (addr_q),
    .look_bank_i (req_bank_i),
    .open_o      (open_vec),
    .look_row_o  (look_row)
  );

  assign req_ready_o = (st_q == ST_IDLE) && done_q && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign bank_open   = open_vec[req_bank_i];
  assign row_hit     = bank_open && (look_row == req_row_i);

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    wcnt_d   = wcnt_q;
    op_d     = op_q;
    bank_d   = bank_q;
    row_d    = row_q;
    col_d    = col_q;
    done_d   = done_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    rd_d     = 1'b0;
    wr_d     = 1'b0;
    fire     = 1'b0;
    ref_ack  = 1'b0;
    launch   = step_q;
    cur_op   = op_q;
    cur_bank = bank_q;
    cur_row  = row_q;
    cur_col  = col_q;

    case (st_q)
      ST_IDLE: begin
        if (done_q && ref_pend) begin
          fire   = 1'b1;
          launch = (|open_vec) ? STEP_PREALL : STEP_REF;
        end else if (accept) begin
          op_d     = req_op_i;
          bank_d   = req_bank_i;
          row_d    = req_row_i;
          col_d    = req_col_i;
          cur_op   = req_op_i;
          cur_bank = req_bank_i;
          cur_row  = req_row_i;
          cur_col  = req_col_i;
          if (req_op_i != OP_NONE) begin
            fire = 1'b1;
            if (req_op_i == OP_FRD && row_hit) launch = STEP_COL;
            else if (bank_open)                launch = STEP_PRE;
            else                               launch = STEP_ACT;
          end
        end
      end
      default: begin
        if (wcnt_q == '0) fire = 1'b1;
        else              wcnt_d = wcnt_q - 1'b1;
      end
    endcase

    if (fire) begin
      case (launch)
        STEP_PRE: begin
          cmd_d  = CMD_PRE;
          ba_d   = cur_bank;
          st_d   = ST_WAIT;
          wcnt_d = CNT_W'(T_RP - 1);
          step_d = STEP_ACT;
        end
        STEP_ACT: begin
          cmd_d  = CMD_ACT;
          ba_d   = cur_bank;
          addr_d = cur_row;
          st_d   = ST_WAIT;
          wcnt_d = CNT_W'(T_RCD - 1);
          step_d = STEP_COL;
        end
        STEP_COL: begin
          cmd_d  = (cur_op == OP_WR) ? CMD_WR : CMD_RD;
          wr_d   = (cur_op == OP_WR);
          rd_d   = (cur_op != OP_WR);
          ba_d   = cur_bank;
          addr_d = cur_col & ~A10_MASK;
          st_d   = ST_IDLE;
        end
        STEP_PREALL: begin
          cmd_d  = CMD_PRE;
          addr_d = A10_MASK;
          st_d   = ST_WAIT;
          wcnt_d = CNT_W'(T_RP - 1);
          step_d = STEP_REF;
        end
        STEP_REF: begin
          cmd_d   = CMD_REF;
          ref_ack = 1'b1;
          st_d    = ST_WAIT;
          wcnt_d  = CNT_W'(T_RFC - 1);
          step_d  = STEP_DONE;
        end
        default: begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_WAIT;
      step_q <= STEP_PREALL;
      wcnt_q <= CNT_W'(INIT_CYC - 1);
      done_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      wcnt_q <= wcnt_d;
      done_q <= done_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
    end
  end

  // request fields only matter once captured; no reset needed
  always_ff @(posedge clk) begin
    op_q   <= op_d;
    bank_q <= bank_d;
    row_q  <= row_d;
    col_q  <= col_d;
  end

  assign cmd_o       = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign wr_go_o     = wr_q;
  assign rd_go_o     = rd_q;
  assign init_done_o = done_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 13,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wr_go_o,
  input logic              rd_go_o,
  input logic              init_done_o
);
  // bank state seen purely from the command bus
  logic [NUM_BANKS-1:0] bus_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_open <= '0;
    end else if (cmd_o == CMD_ACT) begin
      bus_open[ba_o] <= 1'b1;
    end else if (cmd_o == CMD_PRE) begin
      if (addr_o[A10_BIT]) bus_open <= '0;
      else                 bus_open[ba_o] <= 1'b0;
    end
  end

  // R2
  no_req_before_init_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done_o |-> !req_ready_o);

  // R8
  noop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o && req_op_i == OP_NONE) |=> (cmd_o == CMD_NOP));

  // R5
  col_a10_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> !addr_o[A10_BIT]);

  // R6
  col_open_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> bus_open[ba_o]);

  // R6
  act_closed_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_ACT) |-> !bus_open[ba_o]);

  // R9
  ref_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_REF) |-> (bus_open == '0));

  // R3
  wr_go_match_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go_o |-> (cmd_o == CMD_WR));

  // R3
  rd_go_match_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go_o |-> (cmd_o == CMD_RD));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_op_i    (req_op_i),
  .cmd_o       (cmd_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .wr_go_o     (wr_go_o),
  .rd_go_o     (rd_go_o),
  .init_done_o (init_done_o)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_RP   = 3;
  localparam int P_RCD  = 4;
  localparam int P_RFC  = 10;
  localparam int P_REFI = 3000;
  localparam int P_INIT = 30;
  localparam int LOGN   = 64;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [2:0]  req_bank = 3'd0;
  logic [12:0] req_row = '0;
  logic [12:0] req_col = '0;
  logic [2:0]  cmd_o;
  logic [2:0]  ba_o;
  logic [12:0] addr_o;
  logic        wr_go, rd_go, init_done;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [2:0]  lg_cmd [LOGN];
  logic [2:0]  lg_ba  [LOGN];
  logic [12:0] lg_addr[LOGN];
  logic        lg_rd  [LOGN];
  logic        lg_wr  [LOGN];
  int          lg_cyc [LOGN];
  int          lg_n = 0;
  bit          lg_en = 1;

  sdram_cmd_seq #(
    .NUM_BANKS(8), .ADDR_W(13), .T_RP(P_RP), .T_RCD(P_RCD),
    .T_RFC(P_RFC), .REFI(P_REFI), .INIT_CYC(P_INIT)
  ) u_dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .wr_go_o(wr_go), .rd_go_o(rd_go), .init_done_o(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (lg_en && cmd_o != 3'd0 && lg_n < LOGN) begin
      lg_cmd[lg_n]  = cmd_o;
      lg_ba[lg_n]   = ba_o;
      lg_addr[lg_n] = addr_o;
      lg_rd[lg_n]   = rd_go;
      lg_wr[lg_n]   = wr_go;
      lg_cyc[lg_n]  = cyc;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ent(input int i, input int c, input int b, input int a,
                         input int at, input string tag);
    int act, exp;
    exp = (c << 20) | (b << 16) | a;
    if (i >= lg_n) begin
      chk(0, {tag, " entry missing"}, lg_n, i + 1);
    end else begin
      act = (int'(lg_cmd[i]) << 20) | (int'(lg_ba[i]) << 16) | int'(lg_addr[i]);
      chk(act == exp, {tag, " cmd/ba/addr"}, act, exp);
      chk(lg_cyc[i] == at, {tag, " cycle"}, lg_cyc[i], at);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [2:0] b,
                      input logic [12:0] r, input logic [12:0] c, output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = b; req_row = r; req_col = c;
    acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_init(output int at);
    at = -1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (init_done) begin
        req_valid = 1'b0;
        at = cyc;
        break;
      end
    end
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  task automatic t_init();
    int at;
    req_valid = 1'b1; req_op = 2'b10; req_bank = 3'd1;
    repeat (5) begin
      @(negedge clk);
      chk(cmd_o == 3'd0 && !init_done && !req_ready, "R1 reset outputs",
          {cmd_o, init_done, req_ready}, 0);
    end
    rst = 1'b0;
    wait_init(at);
    chk(at >= 0, "R2 init_done rises", at, 1);
    chk(lg_n == 2, "R2 only init commands before ready", lg_n, 2);
    chk_ent(0, C_PRE, 0, 13'h0400, lg_cyc[0], "R2 close-all");
    chk_ent(1, C_REF, 0, 0, lg_cyc[0] + P_RP, "R2 init refresh");
    chk(at - lg_cyc[1] == P_RFC, "R2 done after T_RFC", at - lg_cyc[1], P_RFC);
    settle();
    chk(lg_n == 2, "R2 held request not taken", lg_n, 2);
  endtask

  task automatic t_write_closed();
    int acc;
    lg_n = 0;
    send(2'b10, 3'd3, 13'h0ABC, 13'h0455, acc);
    settle();
    chk(lg_n == 2, "R6 write closed count", lg_n, 2);
    chk_ent(0, C_ACT, 3, 13'h0ABC, acc + 1, "R6 write ACT");
    chk_ent(1, C_WR, 3, 13'h0055, acc + 1 + P_RCD, "R5 write col A10 low");
    chk(lg_wr[1] && !lg_rd[1], "R3 wr_go on WR", {lg_wr[1], lg_rd[1]}, 2);
  endtask

  task automatic t_read_normal();
    int acc;
    lg_n = 0;
    send(2'b01, 3'd3, 13'h0ABC, 13'h0012, acc);
    settle();
    chk(lg_n == 3, "R6 normal read on open bank count", lg_n, 3);
    chk_ent(0, C_PRE, 3, 0, acc + 1, "R5 single-bank PRE");
    chk_ent(1, C_ACT, 3, 13'h0ABC, acc + 1 + P_RP, "R6 ACT after T_RP");
    chk_ent(2, C_RD, 3, 13'h0012, acc + 1 + P_RP + P_RCD, "R6 RD after T_RCD");
    chk(lg_rd[2] && !lg_wr[2], "R3 rd_go on RD", {lg_rd[2], lg_wr[2]}, 2);
  endtask

  task automatic t_fast_hit();
    int acc;
    lg_n = 0;
    send(2'b11, 3'd3, 13'h0ABC, 13'h0020, acc);
    settle();
    chk(lg_n == 1, "R7 fast hit single command", lg_n, 1);
    chk_ent(0, C_RD, 3, 13'h0020, acc + 1, "R7 fast hit RD");
  endtask

  task automatic t_fast_miss();
    int acc;
    lg_n = 0;
    send(2'b11, 3'd3, 13'h1234, 13'h0007, acc);
    settle();
    chk(lg_n == 3, "R7 fast miss count", lg_n, 3);
    chk_ent(0, C_PRE, 3, 0, acc + 1, "R7 fast miss PRE");
    chk_ent(1, C_ACT, 3, 13'h1234, acc + 1 + P_RP, "R7 fast miss ACT");
    chk_ent(2, C_RD, 3, 13'h0007, acc + 1 + P_RP + P_RCD, "R7 fast miss RD");
  endtask

  task automatic t_fast_closed();
    int acc;
    lg_n = 0;
    send(2'b11, 3'd6, 13'h0001, 13'h0003, acc);
    settle();
    chk(lg_n == 2, "R7 fast closed count", lg_n, 2);
    chk_ent(0, C_ACT, 6, 13'h0001, acc + 1, "R4 bank 6 ACT");
    chk_ent(1, C_RD, 6, 13'h0003, acc + 1 + P_RCD, "R7 fast closed RD");
  endtask

  task automatic t_noop();
    int acc;
    lg_n = 0;
    send(2'b00, 3'd5, 13'h0077, 13'h0001, acc);
    settle();
    chk(lg_n == 0, "R8 no-op issues nothing", lg_n, 0);
    chk(req_ready, "R8 no-op leaves sequencer ready", req_ready, 1);
  endtask

  task automatic t_banks();
    int acc;
    lg_n = 0;
    send(2'b10, 3'd0, 13'h0100, 13'h0001, acc);
    settle();
    send(2'b11, 3'd7, 13'h0200, 13'h0002, acc);
    settle();
    chk(lg_n == 4, "R4 two banks opened", lg_n, 4);
    lg_n = 0;
    send(2'b11, 3'd0, 13'h0100, 13'h0009, acc);
    settle();
    chk(lg_n == 1, "R4 bank 0 still open", lg_n, 1);
    chk_ent(0, C_RD, 0, 13'h0009, acc + 1, "R4 bank 0 hit");
    lg_n = 0;
    send(2'b11, 3'd6, 13'h0001, 13'h0004, acc);
    settle();
    chk(lg_n == 1, "R4 bank 6 still open", lg_n, 1);
    chk_ent(0, C_RD, 6, 13'h0004, acc + 1, "R4 bank 6 hit");
    lg_n = 0;
    send(2'b10, 3'd7, 13'h0200, 13'h0005, acc);
    settle();
    chk(lg_n == 3, "R6 write to open same row reopens", lg_n, 3);
    chk_ent(0, C_PRE, 7, 0, acc + 1, "R6 write PRE bank 7");
    chk_ent(2, C_WR, 7, 13'h0005, acc + 1 + P_RP + P_RCD, "R6 write WR bank 7");
  endtask

  task automatic t_reset_mid();
    int acc, at;
    lg_n = 0;
    send(2'b01, 3'd2, 13'h0033, 13'h0044, acc);
    rst = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(cmd_o == 3'd0 && !init_done && !req_ready, "R1 reset mid-sequence",
          {cmd_o, init_done, req_ready}, 0);
    end
    chk(lg_n == 1, "R1 column command abandoned", lg_n, 1);
    rst = 1'b0;
    wait_init(at);
    chk(at >= 0, "R1 re-initialized", at, 1);
    settle();
    lg_n = 0;
    send(2'b11, 3'd3, 13'h1234, 13'h0008, acc);
    settle();
    chk(lg_n == 2, "R1 banks closed after reset", lg_n, 2);
    chk_ent(0, C_ACT, 3, 13'h1234, acc + 1, "R1 ACT without PRE");
  endtask

  task automatic t_refresh();
    int pre_c, ref_c, rds, rd_between;
    pre_c = -1; ref_c = -1; rds = 0; rd_between = 0;
    lg_en = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; req_bank = 3'd3;
    req_row = 13'h1234; req_col = 13'h0010;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (cmd_o == 3'd4 && addr_o[10]) pre_c = cyc;
      else if (cmd_o == 3'd2) begin
        rds++;
        if (pre_c >= 0) rd_between++;
      end else if (cmd_o == 3'd5) begin
        ref_c = cyc;
        break;
      end
    end
    chk(rds > 0, "R9 stream served before refresh", rds, 1);
    chk(ref_c >= 0, "R9 refresh not starved", ref_c, 1);
    chk(pre_c >= 0 && ref_c - pre_c == P_RP, "R9 close-all T_RP before REF",
        ref_c - pre_c, P_RP);
    chk(rd_between == 0, "R9 refresh outranks requests", rd_between, 0);
    for (int j = 1; j <= P_RFC + 1 + P_RCD; j++) begin
      @(negedge clk);
      if (j <= P_RFC)
        chk(cmd_o == 3'd0, "R10 quiet after REF", cmd_o, 0);
      if (j == P_RFC - 1)
        chk(!req_ready, "R10 not ready inside T_RFC", req_ready, 0);
      if (j == P_RFC)
        chk(req_ready, "R10 ready at T_RFC", req_ready, 1);
      if (j == P_RFC + 1)
        chk(cmd_o == 3'd1 && ba_o == 3'd3 && addr_o == 13'h1234,
            "R9 rows closed by refresh", {cmd_o, ba_o, addr_o}, {3'd1, 3'd3, 13'h1234});
      if (j == P_RFC + 1 + P_RCD)
        chk(cmd_o == 3'd2, "R7 RD after reopen", cmd_o, 2);
    end
    req_valid = 1'b0;
    settle();
    lg_en = 1;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    t_init();
    t_write_closed();
    t_read_normal();
    t_fast_hit();
    t_fast_miss();
    t_fast_closed();
    t_noop();
    t_banks();
    t_reset_mid();
    t_refresh();
    report();
  end

endmodule